// File: doc/BRIEF.md
# Buffered Transmit FIFO Serializer

This block is the transmit datapath of a packet radio that runs in buffered mode. The host pushes every byte that goes on air into a 64-entry byte FIFO through a one-cycle write strobe. That includes preamble, sync pattern and payload, because nothing is inserted on the way out. Bytes move from the FIFO into an 8-bit shift register. They leave as an NRZ bitstream, most significant bit first, with one bit per pulse of an external bit-rate strobe.

A configuration input sets when the first byte is launched: either as soon as one byte is stored, or only once the FIFO is full. The block keeps three sticky flags, each cleared by its own host strobe:
- an empty flag, set when the final stored byte is taken into the shift register;
- a done flag, set when that byte's last bit has been sent;
- an overflow flag, set when a write is dropped.

Dropping the transmit-mode input aborts a transmission at once. The FIFO can be flushed while the block is in standby.

The controller has three states:
- **STANDBY** (transmit mode off).
- **ARMED** (transmit mode on, waiting for the start condition).
- **SHIFT** (a byte is on the wire).

Its transitions are:
- **enter**: STANDBY to ARMED when transmit mode rises.
- **launch**: ARMED to SHIFT on a strobe when the start condition holds.
- **chain**: SHIFT to SHIFT when a byte ends and another is stored.
- **finish**: SHIFT to ARMED when a byte ends and the FIFO is empty.
- **leave**: any state to STANDBY when transmit mode falls. From SHIFT this is the abort.

Top module: `bufq_tx_serializer`

## Requirements
- R1: After reset, `tx_bit`, `busy`, `irq_empty`, `irq_done` and `overflow` are 0, and `fifo_level` is 0.
- R2: A loaded byte is sent MSB first. `tx_bit` shows bit 7 after the strobe edge that loads the byte. Each later strobe edge advances one bit, so bit 7-i is shown after the i-th following strobe.
- R3: With `start_on_full`=0, the first strobe in transmit mode that finds at least one stored byte loads it. With `start_on_full`=1, no byte loads until `fifo_level` is 64, and the next strobe then loads.
- R4: When a byte's eighth bit period ends on a strobe and the FIFO holds a byte, that byte loads on the same strobe, with no gap. When the block is not shifting, `tx_bit` is 0.
- R5: `irq_empty` is set by the load that takes the last stored byte, leaving `fifo_level` at 0. An earlier load leaves it clear.
- R6: `irq_done` is set, and `busy` and `tx_bit` fall, on the eighth strobe after the last byte loaded, if no byte is stored at that strobe. On the seventh strobe `irq_done` is still 0.
- R7: Packet length is unlimited. A byte written after `irq_empty` and before the eighth strobe continues the stream without a gap and without raising `irq_done`.
- R8: If `tx_mode` falls while shifting, the next clock edge forces `tx_bit` and `busy` to 0, empties the FIFO, and does not set `irq_done`.
- R9: `fifo_clear` empties the FIFO only when `tx_mode` is 0. In transmit mode it leaves `fifo_level` unchanged.
- R10: A write while `fifo_level` is 64 is dropped: the level stays at 64 and `overflow` is set.
- R11: Each flag stays set until its own clear strobe (`clr_empty`, `clr_done`, `clr_ovf`). The strobe clears it one edge later.
- R12: `busy` is 1 from the launch load until the done event or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_mode | input | 1 | 1 = transmit mode, 0 = standby |
| start_on_full | input | 1 | Start policy: 0 = start when not empty, 1 = start when full |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to store |
| fifo_clear | input | 1 | Flush the FIFO (honoured in standby only) |
| bit_stb | input | 1 | Bit-rate strobe, one clock wide |
| clr_empty | input | 1 | Clears irq_empty |
| clr_done | input | 1 | Clears irq_done |
| clr_ovf | input | 1 | Clears overflow |
| tx_bit | output | 1 | NRZ serial output |
| busy | output | 1 | Transmission in progress |
| irq_empty | output | 1 | Sticky FIFO-empty interrupt |
| irq_done | output | 1 | Sticky transmit-done interrupt |
| overflow | output | 1 | Sticky dropped-write flag |
| fifo_level | output | 7 | Bytes stored (0 to 64) |

## Verification
Every result of a strobe appears at the clock edge where `bit_stb` is high:
- the load or shift of `tx_bit`;
- the setting of `irq_empty` and `irq_done`;
- the fall of `busy`.

The bench therefore raises the strobe on a falling edge and samples on the next falling edge, exactly one register stage later.

Writes, clears and the fall of `tx_mode` likewise take effect at the first rising edge. Their checks also sample one falling edge later. Done timing is checked on both sides of the edge: the flag is still clear after the seventh strobe following the last load, and set after the eighth.

// File: rtl/bufq_tx_pkg.sv
package bufq_tx_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_ARMED   = 2'd1,
        ST_SHIFT   = 2'd2
    } tx_state_t;
endpackage

// File: rtl/bufq_tx_fifo.sv
module bufq_tx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic              clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              push_ok,
    output logic              drop
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = wr_en && !full && !clr;
    assign drop    = wr_en && full && !clr;
    assign rd_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10
    fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH));

    // R10
    full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop && !clr) |=> $stable(count));

    // R5
    no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/bufq_tx_shifter.sv
module bufq_tx_shifter #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              kill,
    input  logic [DATA_W-1:0] din,
    output logic              tx_bit,
    output logic              last_bit
);
    logic [DATA_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;

    assign tx_bit   = sr[DATA_W-1];
    assign last_bit = (cnt == CNT_W'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (kill) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= din;
            cnt <= '0;
        end else if (shift) begin
            sr  <= {sr[DATA_W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    msb_first_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && !kill) |=> tx_bit == $past(sr[DATA_W-2]));

    // R2
    load_shows_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !kill) |=> tx_bit == $past(din[DATA_W-1]));
endmodule

// File: rtl/bufq_tx_ctrl.sv
module bufq_tx_ctrl
    import bufq_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_mode,
    input  logic start_on_full,
    input  logic bit_stb,
    input  logic fifo_clear,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic fifo_one,
    input  logic push_ok,
    input  logic drop,
    input  logic last_bit,
    input  logic clr_empty,
    input  logic clr_done,
    input  logic clr_ovf,
    output logic pop,
    output logic shift,
    output logic kill,
    output logic fifo_clr,
    output logic busy,
    output logic irq_empty,
    output logic irq_done,
    output logic overflow
);
    tx_state_t state_q, state_d;
    logic start_ok, launch, byte_end, chain, finish, abort;

    always_comb begin
        start_ok = start_on_full ? fifo_full : !fifo_empty;
        launch   = (state_q == ST_ARMED) && tx_mode && bit_stb && start_ok;
        byte_end = (state_q == ST_SHIFT) && tx_mode && bit_stb && last_bit;
        chain    = byte_end && !fifo_empty;
        finish   = byte_end && fifo_empty;
        abort    = (state_q == ST_SHIFT) && !tx_mode;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (tx_mode) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!tx_mode)    state_d = ST_STANDBY;
                else if (launch) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!tx_mode)    state_d = ST_STANDBY;
                else if (finish) state_d = ST_ARMED;
            end
            default: state_d = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = (state_q == ST_SHIFT);
        pop      = launch || chain;
        shift    = (state_q == ST_SHIFT) && tx_mode && bit_stb && !last_bit;
        kill     = finish || abort;
        fifo_clr = (fifo_clear && !tx_mode) || abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_empty <= 1'b0;
            irq_done  <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if (pop && fifo_one && !push_ok) irq_empty <= 1'b1;
            else if (clr_empty)              irq_empty <= 1'b0;
            if (finish)                      irq_done  <= 1'b1;
            else if (clr_done)               irq_done  <= 1'b0;
            if (drop)                        overflow  <= 1'b1;
            else if (clr_ovf)                overflow  <= 1'b0;
        end
    end

    // R5
    empty_irq_on_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_empty) |-> $past(pop));

    // R6
    done_from_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_done) |-> $past(state_q == ST_SHIFT) && !busy);

    // R3
    full_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && start_on_full && !fifo_full) |=> !busy);
endmodule

// File: rtl/bufq_tx_serializer.sv
module bufq_tx_serializer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              start_on_full,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fifo_clear,
    input  logic              bit_stb,
    input  logic              clr_empty,
    input  logic              clr_done,
    input  logic              clr_ovf,
    output logic              tx_bit,
    output logic              busy,
    output logic              irq_empty,
    output logic              irq_done,
    output logic              overflow,
    output logic [LVL_W-1:0]  fifo_level
);
    logic [DATA_W-1:0] rd_data;
    logic full, empty, push_ok, drop, pop, shift, kill, fifo_clr, last_bit;

    bufq_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pop(pop), .clr(fifo_clr), .rd_data(rd_data), .count(fifo_level),
        .full(full), .empty(empty), .push_ok(push_ok), .drop(drop)
    );

    bufq_tx_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .load(pop), .shift(shift), .kill(kill),
        .din(rd_data), .tx_bit(tx_bit), .last_bit(last_bit)
    );

    bufq_tx_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode),
        .start_on_full(start_on_full), .bit_stb(bit_stb),
        .fifo_clear(fifo_clear), .fifo_full(full), .fifo_empty(empty),
        .fifo_one(fifo_level == LVL_W'(1)), .push_ok(push_ok), .drop(drop),
        .last_bit(last_bit), .clr_empty(clr_empty), .clr_done(clr_done),
        .clr_ovf(clr_ovf), .pop(pop), .shift(shift), .kill(kill),
        .fifo_clr(fifo_clr), .busy(busy), .irq_empty(irq_empty),
        .irq_done(irq_done), .overflow(overflow)
    );

    // R8
    abort_stops_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_mode && busy) |=> !busy && !tx_bit && fifo_level == '0);

    // R4
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_bit);
endmodule

// File: tb/bufq_tx_serializer_tb_top.sv
module bufq_tx_serializer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_mode = 1'b0, start_on_full = 1'b0, wr_en = 1'b0, fifo_clear = 1'b0;
    logic bit_stb = 1'b0, clr_empty = 1'b0, clr_done = 1'b0, clr_ovf = 1'b0;
    logic [7:0] wr_data = '0;
    logic tx_bit, busy, irq_empty, irq_done, overflow;
    logic [6:0] fifo_level;
    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] bytes [64];

    always #4 clk = ~clk;

    bufq_tx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .start_on_full(start_on_full),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_clear(fifo_clear), .bit_stb(bit_stb),
        .clr_empty(clr_empty), .clr_done(clr_done), .clr_ovf(clr_ovf),
        .tx_bit(tx_bit), .busy(busy), .irq_empty(irq_empty), .irq_done(irq_done),
        .overflow(overflow), .fifo_level(fifo_level)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) bit_stb = 1'b1;
        @(negedge clk) bit_stb = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk) begin clr_empty = 1'b1; clr_done = 1'b1; clr_ovf = 1'b1; end
        @(negedge clk) begin clr_empty = 1'b0; clr_done = 1'b0; clr_ovf = 1'b0; end
    endtask

    task automatic pulse_clear();
        @(negedge clk) fifo_clear = 1'b1;
        @(negedge clk) fifo_clear = 1'b0;
    endtask

    // Sends n preloaded bytes and checks every bit, flag and the done edge.
    task automatic run_burst(input int n);
        for (int k = 0; k < n; k++) wr(bytes[k]);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                strobe();
                check("R2 bit", tx_bit, bytes[k][7-i]);
                if (i == 0) begin
                    check("R12 busy", busy, 1);
                    check("R5 empty flag", irq_empty, (k == n - 1) ? 1 : 0);
                end
            end
        end
        check("R6 done before eighth strobe", irq_done, 0);
        strobe();
        check("R6 done", irq_done, 1);
        check("R6 busy falls", busy, 0);
        check("R4 idle low", tx_bit, 0);
        clear_flags();
        check("R11 flags cleared", irq_done | irq_empty, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_bit", tx_bit, 0);
        check("R1 busy", busy, 0);
        check("R1 flags", {irq_empty, irq_done, overflow}, 0);
        check("R1 level", fifo_level, 0);

        // R3 policy 0: no start while empty, then start on first stored byte
        tx_mode = 1'b1;
        strobe(); strobe();
        check("R3 idle while empty", busy, 0);
        bytes[0] = 8'hA5; bytes[1] = 8'h3C;
        run_burst(2);

        // R7: extend the stream after the empty event
        wr(8'h81);
        strobe();
        check("R2 first bit", tx_bit, 1);
        check("R5 empty on last load", irq_empty, 1);
        @(negedge clk) clr_empty = 1'b1;
        @(negedge clk) clr_empty = 1'b0;
        check("R11 empty cleared", irq_empty, 0);
        wr(8'h7E);
        for (int i = 1; i < 8; i++) begin
            strobe();
            check("R7 first byte bit", tx_bit, (8'h81 >> (7 - i)) & 1);
        end
        for (int i = 0; i < 8; i++) begin
            strobe();
            check("R7 chained bit", tx_bit, (8'h7E >> (7 - i)) & 1);
            check("R7 no done", irq_done, 0);
        end
        check("R5 empty after chain", irq_empty, 1);
        strobe();
        check("R6 done after extension", irq_done, 1);
        clear_flags();

        // Sweep of burst lengths and arithmetic byte patterns
        for (int n = 1; n <= 6; n++) begin
            for (int k = 0; k < n; k++) bytes[k] = 8'((n * 53 + k * 29 + 7) & 255);
            run_burst(n);
        end

        // R3 policy 1 and R8 abort
        tx_mode = 1'b0;
        @(negedge clk) start_on_full = 1'b1;
        @(negedge clk) tx_mode = 1'b1;
        for (int k = 0; k < 63; k++) wr((k == 0) ? 8'hFF : 8'(k));
        strobe(); strobe(); strobe();
        check("R3 waits for full", busy, 0);
        check("R4 idle low", tx_bit, 0);
        wr(8'h40);
        check("R3 level full", fifo_level, 64);
        strobe();
        check("R3 starts when full", busy, 1);
        check("R3 first bit", tx_bit, 1);
        strobe(); strobe();
        check("R2 bit held", tx_bit, 1);
        @(negedge clk) tx_mode = 1'b0;
        @(negedge clk);
        check("R8 line low", tx_bit, 0);
        check("R8 busy low", busy, 0);
        check("R8 fifo emptied", fifo_level, 0);
        check("R8 no done", irq_done, 0);

        // R9 clear ignored in transmit mode, honoured in standby
        @(negedge clk) tx_mode = 1'b1;
        for (int k = 0; k < 5; k++) wr(8'(k + 1));
        pulse_clear();
        check("R9 clear ignored in tx", fifo_level, 5);
        @(negedge clk) tx_mode = 1'b0;
        pulse_clear();
        check("R9 clear in standby", fifo_level, 0);

        // R10 overflow
        for (int k = 0; k < 64; k++) wr(8'(k));
        check("R10 no overflow at 64", overflow, 0);
        wr(8'hEE);
        check("R10 level held", fifo_level, 64);
        check("R10 overflow set", overflow, 1);
        repeat (5) @(negedge clk);
        check("R11 overflow sticky", overflow, 1);
        @(negedge clk) clr_ovf = 1'b1;
        @(negedge clk) clr_ovf = 1'b0;
        check("R11 overflow cleared", overflow, 0);
        pulse_clear();
        check("R9 clear in standby", fifo_level, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule